// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a page-table entry by walking a two-level table held in memory. The upper ten address bits pick a word in the page directory, which sits at the 4 KB-aligned base taken from `dir_base[31:12]`. The next ten bits pick a word in the page table that the directory entry points to. The low twelve bits are the offset inside the 4 KB page and take no part in the walk. Each level is checked for presence and for access rights. On success the block returns the final entry with its accessed bit set, and with its dirty bit set when the access is a write. When the walk cannot complete, it raises a fault and reports the cause.

A translation cache that already holds the directory entry can pass it in with the request. The walker then skips the directory read and goes straight to the table read. The walker uses one 32-bit memory port. It holds each request until the memory acknowledges it, and it writes an entry back only when its accessed or dirty bit has to change.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, done, fault, mem_req and mem_we are all 0.
- R2: The directory entry is read from {dir_base[31:12], vaddr[31:22], 2'b00}. The table entry is read from {pde[31:12], vaddr[21:12], 2'b00}.
- R3: A successful walk pulses done for one cycle. pte_out then equals the table entry with bit 5 (accessed) set and, on a write, bit 6 (dirty) set. Every other bit passes through unchanged, including bit 3 (write-through), bit 4 (cache disable), bit 7 (page size) and bit 8 (global).
- R4: A directory or table entry with bit 0 (present) equal to 0 ends the walk with a one-cycle fault pulse and fault_prot = 0. No later entry is read and nothing is written.
- R5: A user access (req_user = 1) to an entry with bit 2 = 0, or a write (req_write = 1) to an entry with bit 1 = 0, gives a fault with fault_prot = 1. The walk ends at the level where the violation is found.
- R6: During the fault pulse, fault_vaddr, fault_write and fault_user show the virtual address, the write flag and the user flag of the request.
- R7: A fetched directory entry whose bit 5 is 0 is written back with bit 5 set. The table entry is written back only if bit 5 or (on a write) bit 6 changes. A walk that changes neither entry writes nothing.
- R8: When req_pde_hit = 1, req_pde is used as the directory entry. The directory is neither read nor written, and only the table entry is accessed.
- R9: While mem_req = 1 and mem_ack = 0, mem_req, mem_we, mem_addr and mem_wdata stay stable.
- R10: A request presented while busy = 1 is ignored. It causes no memory access and no done or fault pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (accepted only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_pde_hit | input | 1 | A cached directory entry is supplied |
| req_pde | input | 32 | Cached directory entry |
| dir_base | input | 32 | Directory base, bits 31:12 used |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| done | output | 1 | One-cycle success pulse |
| pte_out | output | 32 | Updated table entry, valid with done |
| fault | output | 1 | One-cycle fault pulse |
| fault_prot | output | 1 | 1 = protection violation, 0 = entry not present |
| fault_write | output | 1 | Faulting access was a write |
| fault_user | output | 1 | Faulting access was in user mode |
| fault_vaddr | output | 32 | Faulting virtual address |

## Verification
The bench goes after the writeback decision. A walker that writes back every time shows up through an extra write when both bits are already set. One that forgets the directory entry leaves the stored word with bit 5 clear. A walker that checks rights before presence, or mixes up the two fault kinds, reports the wrong fault_prot for a not-present entry. One that keeps walking after a fault is caught by a second read or a stray write. The bench runs some walks with a slow memory, so an address that drifts before the acknowledge fetches the wrong word. It also runs some walks with a cached directory entry, so a walker that still reads the directory shows an extra read. A request raised mid-walk must leave no trace.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic        req_pde_hit,
  input  logic [31:0] req_pde,
  input  logic [31:0] dir_base,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        done,
  output logic [31:0] pte_out,
  output logic        fault,
  output logic        fault_prot,
  output logic        fault_write,
  output logic        fault_user,
  output logic [31:0] fault_vaddr
);
  localparam int B_P = 0, B_RW = 1, B_US = 2, B_A = 5, B_D = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_PDE, S_CK_PDE, S_RD_PTE, S_CK_PTE,
    S_WB_PDE, S_WB_PTE, S_DONE, S_FAULT
  } st_t;

  st_t         st;
  logic [31:0] va, pde, pte;
  logic [19:0] base;
  logic        wr, usr, pde_wb, pte_wb;

  wire pde_bad = (usr && !pde[B_US]) || (wr && !pde[B_RW]);
  wire pte_bad = (usr && !pte[B_US]) || (wr && !pte[B_RW]);
  wire [31:0] pde_addr = {base, va[31:22], 2'b00};
  wire [31:0] pte_addr = {pde[31:12], va[21:12], 2'b00};

  assign busy        = (st != S_IDLE);
  assign mem_req     = (st == S_RD_PDE) || (st == S_RD_PTE) || mem_we;
  assign mem_we      = (st == S_WB_PDE) || (st == S_WB_PTE);
  assign mem_addr    = (st == S_RD_PDE || st == S_WB_PDE) ? pde_addr : pte_addr;
  assign mem_wdata   = (st == S_WB_PDE) ? (pde | (32'd1 << B_A)) : pte;
  assign done        = (st == S_DONE);
  assign fault       = (st == S_FAULT);
  assign pte_out     = pte;
  assign fault_vaddr = va;
  assign fault_write = wr;
  assign fault_user  = usr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; va <= '0; pde <= '0; pte <= '0; base <= '0;
      wr <= 1'b0; usr <= 1'b0; pde_wb <= 1'b0; pte_wb <= 1'b0; fault_prot <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va <= req_vaddr; wr <= req_write; usr <= req_user;
          base <= dir_base[31:12]; pde_wb <= 1'b0; pte_wb <= 1'b0;
          if (req_pde_hit) begin
            pde <= req_pde;
            st  <= S_RD_PTE;
          end else begin
            st <= S_RD_PDE;
          end
        end
        S_RD_PDE: if (mem_ack) begin
          pde <= mem_rdata;
          st  <= S_CK_PDE;
        end
        S_CK_PDE: begin
          if (!pde[B_P]) begin
            fault_prot <= 1'b0; st <= S_FAULT;
          end else if (pde_bad) begin
            fault_prot <= 1'b1; st <= S_FAULT;
          end else begin
            pde_wb <= !pde[B_A]; st <= S_RD_PTE;
          end
        end
        S_RD_PTE: if (mem_ack) begin
          pte <= mem_rdata;
          st  <= S_CK_PTE;
        end
        S_CK_PTE: begin
          if (!pte[B_P]) begin
            fault_prot <= 1'b0; st <= S_FAULT;
          end else if (pte_bad) begin
            fault_prot <= 1'b1; st <= S_FAULT;
          end else begin
            pte[B_A] <= 1'b1;
            if (wr) pte[B_D] <= 1'b1;
            pte_wb <= !pte[B_A] || (wr && !pte[B_D]);
            if (pde_wb) st <= S_WB_PDE;
            else if (!pte[B_A] || (wr && !pte[B_D])) st <= S_WB_PTE;
            else st <= S_DONE;
          end
        end
        S_WB_PDE: if (mem_ack) st <= pte_wb ? S_WB_PTE : S_DONE;
        S_WB_PTE: if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3
  pte_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pte_out[B_P] && pte_out[B_A]);

  // R3
  wr_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && wr |-> pte_out[B_D]);

  // R7
  wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[B_A] && mem_wdata[B_P]);

  // R10
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_user = 0, req_pde_hit = 0;
  logic [31:0] req_vaddr = 0, req_pde = 0, dir_base = 32'h0000_1000;
  logic busy, mem_req, mem_we, done, fault, fault_prot, fault_write, fault_user;
  logic [31:0] mem_addr, mem_wdata, pte_out, fault_vaddr;
  logic [31:0] mem_rdata = 0;
  logic mem_ack = 0;

  always #2.5 clk = ~clk;

  pt_walker u0 (.*);

  logic [31:0] mem [0:4095];
  int lat = 0, wcnt = 0, nrd = 0, nwr = 0;
  logic [31:0] last_ra = 0, prev_ra = 0, last_wa = 0;
  int vectors = 0, errors = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1; wcnt <= 0;
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata; nwr <= nwr + 1; last_wa <= mem_addr;
        end else begin
          mem_rdata <= mem[mem_addr[13:2]]; nrd <= nrd + 1;
          prev_ra <= last_ra; last_ra <= mem_addr;
        end
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  int r0, w0;
  logic got_done, got_fault, g_prot, g_wr, g_usr;
  logic [31:0] g_pte, g_va;

  task automatic walk(input logic [31:0] va, input logic w, input logic u,
                      input logic hit, input logic [31:0] cp);
    r0 = nrd; w0 = nwr; got_done = 0; got_fault = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w; req_user = u;
    req_pde_hit = hit; req_pde = cp;
    @(negedge clk);
    req_valid = 0; req_pde_hit = 0;
    for (int i = 0; i < 200 && !(done || fault); i++) @(negedge clk);
    got_done = done; got_fault = fault; g_pte = pte_out; g_prot = fault_prot;
    g_wr = fault_write; g_usr = fault_user; g_va = fault_vaddr;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 fault", fault, 0);
    chk("R1 mem_req", mem_req, 0); chk("R1 mem_we", mem_we, 0);
  endtask

  task automatic t_read_first;
    walk(32'h00C0_5123, 0, 1, 0, 0);
    chk("R3 done", got_done, 1); chk("R3 pte", g_pte, 32'h0000_5027);
    chk("R2 pde addr", prev_ra, 32'h0000_100C); chk("R2 pte addr", last_ra, 32'h0000_2014);
    chk("R7 writes", nwr - w0, 2);
    chk("R7 pde mem", mem[12'h403], 32'h0000_2027); chk("R7 pte mem", mem[12'h805], 32'h0000_5027);
  endtask

  task automatic t_write_pass;
    walk(32'h00C0_A004, 1, 0, 0, 0);
    chk("R3 pte passthru", g_pte, 32'h0000_517F);
    chk("R7 one write", nwr - w0, 1); chk("R7 wb addr", last_wa, 32'h0000_2028);
    chk("R7 wb data", mem[12'h80A], 32'h0000_517F);
  endtask

  task automatic t_no_change;
    walk(32'h00C0_B000, 1, 1, 0, 0);
    chk("R3 pte ps", g_pte, 32'h0000_60E7); chk("R7 no write", nwr - w0, 0);
  endtask

  task automatic t_not_present;
    walk(32'h0100_0010, 0, 0, 0, 0);
    chk("R4 pde fault", got_fault, 1); chk("R4 kind", g_prot, 0);
    chk("R4 reads", nrd - r0, 1); chk("R4 writes", nwr - w0, 0);
    chk("R6 vaddr", g_va, 32'h0100_0010);
    walk(32'h00C0_6000, 0, 0, 0, 0);
    chk("R4 pte fault", got_fault, 1); chk("R4 kind2", g_prot, 0);
    chk("R4 reads2", nrd - r0, 2); chk("R4 writes2", nwr - w0, 0);
  endtask

  task automatic t_protection;
    walk(32'h00C0_7ABC, 0, 1, 0, 0);
    chk("R5 user fault", got_fault, 1); chk("R5 kind", g_prot, 1);
    chk("R6 user", g_usr, 1); chk("R6 write", g_wr, 0); chk("R6 va", g_va, 32'h00C0_7ABC);
    chk("R5 no write", nwr - w0, 0);
    walk(32'h00C0_7ABC, 0, 0, 0, 0);
    chk("R5 super ok", got_done, 1); chk("R5 super pte", g_pte, 32'h0000_8023);
    walk(32'h00C0_8000, 1, 1, 0, 0);
    chk("R5 ro fault", g_prot & got_fault, 1); chk("R6 write1", g_wr, 1);
    walk(32'h0140_0000, 1, 0, 0, 0);
    chk("R5 pde ro", g_prot & got_fault, 1); chk("R5 pde reads", nrd - r0, 1);
    chk("R6 user0", g_usr, 0);
  endtask

  task automatic t_cached;
    walk(32'h0240_5000, 0, 0, 1, 32'h0000_2007);
    chk("R8 done", got_done, 1); chk("R8 pte", g_pte, 32'h0000_5027);
    chk("R8 reads", nrd - r0, 1); chk("R8 addr", last_ra, 32'h0000_2014);
    chk("R8 writes", nwr - w0, 0);
  endtask

  task automatic t_busy;
    lat = 3;
    r0 = nrd; w0 = nwr;
    @(negedge clk);
    req_valid = 1; req_vaddr = 32'h00C0_C000; req_write = 0; req_user = 0;
    @(negedge clk);
    req_vaddr = 32'h0100_0010;
    @(negedge clk);
    req_valid = 0;
    got_done = 0; got_fault = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) begin got_done = 1; g_pte = pte_out; end
      if (fault) got_fault = 1;
    end
    chk("R10 done", got_done, 1); chk("R9 pte slow", g_pte, 32'h0000_A027);
    chk("R10 no fault", got_fault, 0); chk("R10 reads", nrd - r0, 2);
    chk("R10 writes", nwr - w0, 0);
    lat = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[12'h403] = 32'h0000_2007;
    mem[12'h404] = 32'h0000_3006;
    mem[12'h405] = 32'h0000_3025;
    mem[12'h805] = 32'h0000_5007;
    mem[12'h806] = 32'h0000_7006;
    mem[12'h807] = 32'h0000_8003;
    mem[12'h808] = 32'h0000_9005;
    mem[12'h80A] = 32'h0000_513F;
    mem[12'h80B] = 32'h0000_60E7;
    mem[12'h80C] = 32'h0000_A027;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_read_first;
    t_write_pass;
    t_no_change;
    t_not_present;
    t_protection;
    t_cached;
    t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule